// File: doc/BRIEF.md
# DDR3 Power-Up Bring-Up Sequencer

This block is a hardware state machine that brings a DDR3 memory to a usable state after reset, replacing a firmware routine. When `start` is pulsed it first places the PHY read and write phase selections and pulses the PHY reset. It then steps the controller's control word through the power-up stages, issues the four mode-register loads and a ZQ calibration through the phase-0 command port, and hands the controller back to hardware ownership.

After hand-back it programs fixed per-module PHY settings. For each byte module it asserts a one-hot module select and emits single-cycle strobes that reset the write bitslip, reset and advance the read bitslip, and reset and advance the read delay line. This gives a static, board-tuned setup with no calibration loop. Millisecond waits come from a cycle counter sized by the clock-frequency parameter `CLK_KHZ`, so simulation can use a small value.

Top module: `ddr_bringup_seq`

## Requirements
- R1: While reset is held and until `start` is pulsed, `done`, `ctl_word`, `rd_phase`, `wr_phase`, `phy_rst`, `cmd_issue`, `dly_sel` and all five strobes are zero.
- R2: The cycle after `start` is sampled, `rd_phase`=2, `wr_phase`=3, `ctl_word`=0x0 (software ownership) and `phy_rst`=1. `phy_rst` stays high for exactly `CLK_KHZ` cycles (1 ms). It then stays low for `CLK_KHZ` cycles before the next stage begins.
- R3: `ctl_word` is then 0xC (bit2 reset released, bit3 set, bit1 CKE low) for exactly 5·`CLK_KHZ` cycles. It then becomes 0xE (bit1 CKE high). The first command issue comes `CLK_KHZ`+1 cycles after 0xE appears.
- R4: Exactly five commands are issued, in this order as (code, bank, address): (0x0F,2,0x200), (0x0F,3,0x000), (0x0F,1,0x006), (0x0F,0,0x920), (0x03,0,0x400). Code bits are bit0 chip-select, bit1 WE, bit2 CAS, bit3 RAS, bit4 write-enable, bit5 read-enable. All five are issued while `ctl_word` is 0xE.
- R5: Code, bank and address are placed one cycle before `cmd_issue` and are unchanged during it. `cmd_issue` is high for one cycle only. The first four issues are 3 cycles apart except the MR0-to-ZQ spacing.
- R6: The ZQ issue follows the MR0 issue by `SETTLE_CYC`+2 cycles. `ctl_word` becomes 0x1 (hardware ownership) `SETTLE_CYC`+1 cycles after the ZQ issue.
- R7: For module 0 and then module 1, `dly_sel` is one-hot (0b01, then 0b10) for every strobe. Each module receives, in order: one `wslip_rst`, one `rslip_rst`, `RD_SLIP` `rslip_inc`, one `rdly_rst`, `RD_TAPS` `rdly_inc`. At most one strobe is high in any cycle, and no strobe is high two cycles in a row.
- R8: After the last module, `dly_sel` returns to 0 and `done` rises. `done` stays high, with `ctl_word`=0x1, for as long as no new `start` arrives.
- R9: A `start` pulse while the sequence runs has no effect on its timing or command list.
- R10: A `start` pulse after `done` clears `done` and repeats the whole sequence with identical timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin bring-up (sampled when idle or done) |
| done | output | 1 | Bring-up complete, block idle |
| ctl_word | output | 4 | Controller ownership/power-up control word |
| rd_phase | output | 2 | PHY read phase selection |
| wr_phase | output | 2 | PHY write phase selection |
| phy_rst | output | 1 | PHY reset |
| cmd_code | output | 6 | Phase-0 command code |
| cmd_bank | output | 3 | Phase-0 bank address |
| cmd_addr | output | ADDR_W | Phase-0 row/mode address |
| cmd_issue | output | 1 | One-cycle command issue strobe |
| dly_sel | output | MODULES | One-hot byte module select |
| wslip_rst | output | 1 | Write bitslip reset strobe |
| rslip_rst | output | 1 | Read bitslip reset strobe |
| rslip_inc | output | 1 | Read bitslip increment strobe |
| rdly_rst | output | 1 | Read delay reset strobe |
| rdly_inc | output | 1 | Read delay increment strobe |

## Verification
A wrong state or timer value in this block shows up at the ports within one stage. A control-word stage that runs short or long shifts the 0xC, 0xE or 0x1 edges by a measurable number of cycles. A mis-stepped command index changes the code, bank or address at the very next issue. A wrong sub-step or module counter changes the strobe counts or their order under a given `dly_sel`, or leaves `dly_sel` non-zero when `done` rises. A start that leaks into a running sequence restarts the PHY reset, which at once lengthens every later interval.

// File: rtl/ddr_bringup_pkg.sv
package ddr_bringup_pkg;

    localparam logic [3:0] CTL_SW_IDLE = 4'h0;
    localparam logic [3:0] CTL_RST_REL = 4'hC;
    localparam logic [3:0] CTL_CKE_ON  = 4'hE;
    localparam logic [3:0] CTL_HW_OWN  = 4'h1;

    // bit0 CS, bit1 WE, bit2 CAS, bit3 RAS, bit4 wren, bit5 rden
    localparam logic [5:0] CMD_MRS = 6'h0F;
    localparam logic [5:0] CMD_ZQ  = 6'h03;
    localparam int         N_CMDS  = 5;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PHY_RST, ST_PHY_SETTLE, ST_CKE_LOW, ST_CKE_HIGH,
        ST_CMD_LOAD, ST_CMD_ISSUE, ST_CMD_WAIT, ST_HW_CTRL,
        ST_MOD_SEL, ST_MOD_PULSE, ST_MOD_GAP, ST_MOD_CLEAR, ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        STB_NONE, STB_WSLIP_RST, STB_RSLIP_RST, STB_RSLIP_INC,
        STB_RDLY_RST, STB_RDLY_INC
    } strobe_e;

    typedef struct packed {
        logic [5:0]  code;
        logic [2:0]  bank;
        logic [15:0] addr;
    } cmd_entry_t;

    // MR2 (CWL 5), MR3, MR1, MR0 (CL 6, BL 8), then ZQ long calibration
    function automatic cmd_entry_t cmd_entry(input logic [2:0] idx);
        cmd_entry_t e;
        case (idx)
            3'd0:    e = '{code: CMD_MRS, bank: 3'd2, addr: 16'h0200};
            3'd1:    e = '{code: CMD_MRS, bank: 3'd3, addr: 16'h0000};
            3'd2:    e = '{code: CMD_MRS, bank: 3'd1, addr: 16'h0006};
            3'd3:    e = '{code: CMD_MRS, bank: 3'd0, addr: 16'h0920};
            default: e = '{code: CMD_ZQ,  bank: 3'd0, addr: 16'h0400};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/ddr_wait_timer.sv
module ddr_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R3: each wait stage length depends on a strict one-per-cycle countdown
    a_r3_timer_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr_module_step.sv
module ddr_module_step
    import ddr_bringup_pkg::*;
#(
    parameter int RD_SLIP = 1,
    parameter int RD_TAPS = 25,
    parameter int SUB_W   = 5
) (
    input  logic [SUB_W-1:0] sub,
    output strobe_e          kind,
    output logic             last
);
    localparam int N_SUB = 3 + RD_SLIP + RD_TAPS;

    always_comb begin
        if (int'(sub) == 0)
            kind = STB_WSLIP_RST;
        else if (int'(sub) == 1)
            kind = STB_RSLIP_RST;
        else if (int'(sub) < 2 + RD_SLIP)
            kind = STB_RSLIP_INC;
        else if (int'(sub) == 2 + RD_SLIP)
            kind = STB_RDLY_RST;
        else
            kind = STB_RDLY_INC;
        last = (int'(sub) == N_SUB - 1);
    end

endmodule

// File: rtl/ddr_bringup_seq.sv
module ddr_bringup_seq
    import ddr_bringup_pkg::*;
#(
    parameter int CLK_KHZ    = 250000,
    parameter int SETTLE_CYC = 200,
    parameter int RD_TAPS    = 25,
    parameter int RD_SLIP    = 1,
    parameter int MODULES    = 2,
    parameter int ADDR_W     = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               done,
    output logic [3:0]         ctl_word,
    output logic [1:0]         rd_phase,
    output logic [1:0]         wr_phase,
    output logic               phy_rst,
    output logic [5:0]         cmd_code,
    output logic [2:0]         cmd_bank,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic               cmd_issue,
    output logic [MODULES-1:0] dly_sel,
    output logic               wslip_rst,
    output logic               rslip_rst,
    output logic               rslip_inc,
    output logic               rdly_rst,
    output logic               rdly_inc
);
    localparam int MS_CYC = CLK_KHZ;
    localparam int TMR_W  = $clog2(5 * MS_CYC + SETTLE_CYC + 1);
    localparam int N_SUB  = 3 + RD_SLIP + RD_TAPS;
    localparam int SUB_W  = $clog2(N_SUB + 1);
    localparam int MOD_W  = (MODULES > 1) ? $clog2(MODULES) : 1;

    typedef struct packed {
        seq_state_e         st;
        logic [2:0]         cmd_idx;
        logic [MOD_W-1:0]   mod;
        logic [SUB_W-1:0]   sub;
        logic [3:0]         ctl;
        logic               phy_rst;
        logic [1:0]         rdph;
        logic [1:0]         wrph;
        logic [5:0]         code;
        logic [2:0]         bank;
        logic [ADDR_W-1:0]  addr;
        logic               issue;
        logic [MODULES-1:0] sel;
        strobe_e            stb;
        logic               done;
    } regs_t;

    regs_t      d, q;
    logic       tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic       tmr_exp;
    strobe_e    step_kind;
    logic       step_last;
    cmd_entry_t nxt_cmd;
    logic [2:0] nxt_idx;

    ddr_wait_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_exp)
    );

    ddr_module_step #(.RD_SLIP(RD_SLIP), .RD_TAPS(RD_TAPS), .SUB_W(SUB_W)) u_step (
        .sub(q.sub), .kind(step_kind), .last(step_last)
    );

    assign nxt_idx = (q.st == ST_CKE_HIGH) ? 3'd0 : q.cmd_idx + 3'd1;
    assign nxt_cmd = cmd_entry(nxt_idx);

    always_comb begin
        d        = q;
        d.issue  = 1'b0;
        d.stb    = STB_NONE;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    d.st      = ST_PHY_RST;
                    d.done    = 1'b0;
                    d.rdph    = 2'd2;
                    d.wrph    = 2'd3;
                    d.ctl     = CTL_SW_IDLE;
                    d.phy_rst = 1'b1;
                    d.code    = '0;
                    d.bank    = '0;
                    d.addr    = '0;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(MS_CYC - 1);
                end
            end
            ST_PHY_RST: if (tmr_exp) begin
                d.st      = ST_PHY_SETTLE;
                d.phy_rst = 1'b0;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(MS_CYC - 1);
            end
            ST_PHY_SETTLE: if (tmr_exp) begin
                d.st     = ST_CKE_LOW;
                d.ctl    = CTL_RST_REL;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(5 * MS_CYC - 1);
            end
            ST_CKE_LOW: if (tmr_exp) begin
                d.st     = ST_CKE_HIGH;
                d.ctl    = CTL_CKE_ON;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(MS_CYC - 1);
            end
            ST_CKE_HIGH, ST_CMD_WAIT: if (tmr_exp) begin
                if (q.st == ST_CMD_WAIT && q.cmd_idx == 3'(N_CMDS - 1)) begin
                    d.st  = ST_HW_CTRL;
                    d.ctl = CTL_HW_OWN;
                end else begin
                    d.st      = ST_CMD_LOAD;
                    d.cmd_idx = nxt_idx;
                    d.code    = nxt_cmd.code;
                    d.bank    = nxt_cmd.bank;
                    d.addr    = ADDR_W'(nxt_cmd.addr);
                end
            end
            ST_CMD_LOAD: begin
                d.st    = ST_CMD_ISSUE;
                d.issue = 1'b1;
            end
            ST_CMD_ISSUE: begin
                d.st     = ST_CMD_WAIT;
                tmr_load = 1'b1;
                tmr_val  = (q.cmd_idx >= 3'd3) ? TMR_W'(SETTLE_CYC - 1) : '0;
            end
            ST_HW_CTRL: begin
                d.st  = ST_MOD_SEL;
                d.mod = '0;
                d.sub = '0;
                d.sel = MODULES'(1);
            end
            ST_MOD_SEL: begin
                d.st  = ST_MOD_PULSE;
                d.stb = step_kind;
            end
            ST_MOD_PULSE: d.st = ST_MOD_GAP;
            ST_MOD_GAP: begin
                if (!step_last) begin
                    d.st  = ST_MOD_SEL;
                    d.sub = q.sub + 1'b1;
                end else if (q.mod == MOD_W'(MODULES - 1)) begin
                    d.st  = ST_MOD_CLEAR;
                    d.sel = '0;
                end else begin
                    d.st  = ST_MOD_SEL;
                    d.mod = q.mod + 1'b1;
                    d.sub = '0;
                    d.sel = MODULES'(1) << (q.mod + 1'b1);
                end
            end
            ST_MOD_CLEAR: begin
                d.st   = ST_DONE;
                d.done = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.stb <= STB_NONE;
        end else begin
            q <= d;
        end
    end

    assign done      = q.done;
    assign ctl_word  = q.ctl;
    assign rd_phase  = q.rdph;
    assign wr_phase  = q.wrph;
    assign phy_rst   = q.phy_rst;
    assign cmd_code  = q.code;
    assign cmd_bank  = q.bank;
    assign cmd_addr  = q.addr;
    assign cmd_issue = q.issue;
    assign dly_sel   = q.sel;
    assign wslip_rst = (q.stb == STB_WSLIP_RST);
    assign rslip_rst = (q.stb == STB_RSLIP_RST);
    assign rslip_inc = (q.stb == STB_RSLIP_INC);
    assign rdly_rst  = (q.stb == STB_RDLY_RST);
    assign rdly_inc  = (q.stb == STB_RDLY_INC);

    logic [4:0] stb_vec;
    assign stb_vec = {wslip_rst, rslip_rst, rslip_inc, rdly_rst, rdly_inc};

    a_r5_issue_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |=> !cmd_issue);
    a_r5_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> ($stable(cmd_code) && $stable(cmd_bank) && $stable(cmd_addr)));
    a_r4_issue_cke_on: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> (ctl_word == CTL_CKE_ON));
    a_r2_reset_swctl: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst |-> (ctl_word == CTL_SW_IDLE));
    a_r7_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb_vec));
    a_r7_strobe_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_vec != '0) |-> ($countones(dly_sel) == 1));
    a_r7_strobe_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_vec != '0) |=> (stb_vec == '0));
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctl_word == CTL_HW_OWN && dly_sel == '0 && !phy_rst && !cmd_issue));

endmodule

// File: tb/ddr_bringup_seq_test.sv
module ddr_bringup_seq_test;
    localparam int KHZ = 10, SETTLE = 20, TAPS = 25, SLIP = 1, NMOD = 2, AW = 14;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic done, phy_rst, cmd_issue;
    logic [3:0] ctl_word;
    logic [1:0] rd_phase, wr_phase;
    logic [5:0] cmd_code;
    logic [2:0] cmd_bank;
    logic [AW-1:0] cmd_addr;
    logic [NMOD-1:0] dly_sel;
    logic wslip_rst, rslip_rst, rslip_inc, rdly_rst, rdly_inc;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ddr_bringup_seq #(.CLK_KHZ(KHZ), .SETTLE_CYC(SETTLE), .RD_TAPS(TAPS),
                      .RD_SLIP(SLIP), .MODULES(NMOD), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .ctl_word(ctl_word),
        .rd_phase(rd_phase), .wr_phase(wr_phase), .phy_rst(phy_rst),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .cmd_issue(cmd_issue), .dly_sel(dly_sel), .wslip_rst(wslip_rst),
        .rslip_rst(rslip_rst), .rslip_inc(rslip_inc), .rdly_rst(rdly_rst),
        .rdly_inc(rdly_inc));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_code(input int i);
        return (i == 4) ? 'h03 : 'h0F;
    endfunction
    function automatic int exp_bank(input int i);
        case (i) 0: return 2; 1: return 3; 2: return 1; default: return 0; endcase
    endfunction
    function automatic int exp_addr(input int i);
        case (i) 0: return 'h200; 1: return 0; 2: return 6; 3: return 'h920; default: return 'h400; endcase
    endfunction

    // one full bring-up; start pulsed again at cycle inj_k (0 = never)
    task automatic run_seq(input int inj_k, input string tag);
        int k = 0, nis = 0, t_pr1 = -1, t_pr0 = -1, t_c = -1, t_e = -1, t_hw = -1;
        int it[5], ic[5], ib[5], ia[5];
        int cnt[2][5];
        bit seen_rsr[2], seen_rdr[2];
        int unstable = 0, b2b = 0, overlap = 0, bad_sel = 0, bad_order = 0, wide_issue = 0;
        logic [4:0] sv, prev_sv = '0;
        logic prev_issue = 1'b0;
        logic [5:0] pc = '0; logic [2:0] pb = '0; logic [AW-1:0] pa = '0;
        for (int m = 0; m < 2; m++) begin
            seen_rsr[m] = 0; seen_rdr[m] = 0;
            for (int s = 0; s < 5; s++) cnt[m][s] = 0;
        end
        for (int i = 0; i < 5; i++) begin it[i] = 0; ic[i] = 0; ib[i] = 0; ia[i] = 0; end
        @(negedge clk); start = 1'b1;
        while (k < 5000) begin
            @(negedge clk);
            k++;
            start = (k == inj_k);
            if (k == 1) begin
                chk({tag, " R2 rd_phase"}, int'(rd_phase), 2);
                chk({tag, " R2 wr_phase"}, int'(wr_phase), 3);
                chk({tag, " R2 sw ctl"}, int'(ctl_word), 0);
                chk({tag, " R10 done cleared"}, int'(done), 0);
            end
            if (phy_rst && t_pr1 < 0) t_pr1 = k;
            if (!phy_rst && t_pr1 >= 0 && t_pr0 < 0) t_pr0 = k;
            if (ctl_word == 4'hC && t_c < 0) t_c = k;
            if (ctl_word == 4'hE && t_e < 0) t_e = k;
            if (ctl_word == 4'h1 && t_hw < 0) t_hw = k;
            if (cmd_issue) begin
                if (cmd_code != pc || cmd_bank != pb || cmd_addr != pa) unstable++;
                if (prev_issue) wide_issue++;
                if (nis < 5) begin
                    it[nis] = k; ic[nis] = int'(cmd_code);
                    ib[nis] = int'(cmd_bank); ia[nis] = int'(cmd_addr);
                end
                nis++;
            end
            sv = {wslip_rst, rslip_rst, rslip_inc, rdly_rst, rdly_inc};
            if (sv != '0) begin
                int m;
                if (prev_sv != '0) b2b++;
                if ($countones(sv) > 1) overlap++;
                m = (dly_sel == 2'b01) ? 0 : (dly_sel == 2'b10) ? 1 : -1;
                if (m < 0) bad_sel++;
                else begin
                    if (wslip_rst) cnt[m][0]++;
                    if (rslip_rst) begin cnt[m][1]++; seen_rsr[m] = 1; end
                    if (rslip_inc) begin cnt[m][2]++; if (!seen_rsr[m]) bad_order++; end
                    if (rdly_rst)  begin cnt[m][3]++; seen_rdr[m] = 1; end
                    if (rdly_inc)  begin cnt[m][4]++; if (!seen_rdr[m]) bad_order++; end
                    if (m == 1 && cnt[0][4] != TAPS) bad_order++;
                end
            end
            prev_sv = sv; prev_issue = cmd_issue;
            pc = cmd_code; pb = cmd_bank; pa = cmd_addr;
            if (done) break;
        end
        chk({tag, " sequence finished"}, int'(done), 1);
        chk({tag, " R2 phy_rst rises first cycle"}, t_pr1, 1);
        chk({tag, " R2 phy_rst width"}, t_pr0 - t_pr1, KHZ);
        chk({tag, " R2 post-reset wait"}, t_c - t_pr0, KHZ);
        chk({tag, " R3 ctl 0xC hold"}, t_e - t_c, 5 * KHZ);
        chk({tag, " R3 first issue after 0xE"}, it[0] - t_e, KHZ + 1);
        chk({tag, " R4 issue count"}, nis, 5);
        for (int i = 0; i < 5; i++) begin
            chk({tag, " R4 cmd code"}, ic[i], exp_code(i));
            chk({tag, " R4 cmd bank"}, ib[i], exp_bank(i));
            chk({tag, " R4 cmd addr"}, ia[i], exp_addr(i));
        end
        for (int i = 0; i < 3; i++) chk({tag, " R5 mrs spacing"}, it[i+1] - it[i], 3);
        chk({tag, " R5 fields stable at issue"}, unstable, 0);
        chk({tag, " R5 single-cycle issue"}, wide_issue, 0);
        chk({tag, " R6 MR0 to ZQ"}, it[4] - it[3], SETTLE + 2);
        chk({tag, " R6 ZQ to hw ctl"}, t_hw - it[4], SETTLE + 1);
        for (int m = 0; m < 2; m++) begin
            chk({tag, " R7 wslip_rst count"}, cnt[m][0], 1);
            chk({tag, " R7 rslip_rst count"}, cnt[m][1], 1);
            chk({tag, " R7 rslip_inc count"}, cnt[m][2], SLIP);
            chk({tag, " R7 rdly_rst count"}, cnt[m][3], 1);
            chk({tag, " R7 rdly_inc count"}, cnt[m][4], TAPS);
        end
        chk({tag, " R7 strobe order"}, bad_order, 0);
        chk({tag, " R7 select one-hot"}, bad_sel, 0);
        chk({tag, " R7 no overlap"}, overlap, 0);
        chk({tag, " R7 no back-to-back"}, b2b, 0);
        chk({tag, " R8 sel cleared"}, int'(dly_sel), 0);
        chk({tag, " R8 hw ctl at done"}, int'(ctl_word), 1);
    endtask

    initial begin
        int gap, inj;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk("R1 done", int'(done), 0);
        chk("R1 ctl", int'(ctl_word), 0);
        chk("R1 phases", int'({rd_phase, wr_phase}), 0);
        chk("R1 phy_rst", int'(phy_rst), 0);
        chk("R1 issue/sel/strobes",
            int'({cmd_issue, dly_sel, wslip_rst, rslip_rst, rslip_inc, rdly_rst, rdly_inc}), 0);
        @(negedge clk); rst_n = 1'b1;
        gap = 1 + ($urandom % 12);
        repeat (gap) begin
            @(negedge clk);
            chk("R1 idle before start", int'({done, ctl_word, phy_rst, cmd_issue}), 0);
        end
        run_seq(0, "run0");
        gap = 2 + ($urandom % 20);
        repeat (gap) begin
            @(negedge clk);
            chk("R8 done held", int'(done), 1);
        end
        // R9: start pulse inside the 0xC stage
        inj = 2 * KHZ + 3 + ($urandom % (5 * KHZ - 6));
        run_seq(inj, "run1 R9");
        // R9/R10: restart, with a stray start during module programming
        inj = 150 + ($urandom % 100);
        run_seq(inj, "run2 R10");
        repeat (5) @(negedge clk);
        chk("R8 done still held", int'(done), 1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule